// File: doc/BRIEF.md
# Burst Address and Write Control

This block is the address and control front end of a synchronous burst SRAM. A cycle starts when one of two address strobes is asserted while the chip is selected. The block then registers the external address and produces the three following word addresses from a small burst counter. The counter runs in linear or interleaved order, chosen by an order-select input. On cycles with no strobe, an advance input either steps the burst to the next word or suspends it, so that the current word address is used again.

The block also qualifies three chip enables. One is active low and gates the processor strobe. The second is active high and the third active low, and those two are looked at only on strobe cycles. It decodes the global-write, byte-write-enable and per-byte write inputs into byte write strobes. Each strobe covers one 9-bit lane (8 data bits and 1 parity bit) of the 18-bit word. Every output is registered and describes the cycle sampled at the latest rising clock edge. The outputs are the word address, the byte strobes, a write-cycle flag and a deselect flag, and they feed the memory array and the data path that sit next to this block.

Top module: `burst_addr_ctrl`

## Requirements
- R1: With order_sel low (linear), each advance cycle adds 1 modulo 4 to cur_addr[1:0] and leaves cur_addr[17:2] unchanged, for example 01, 10, 11, 00.
- R2: With order_sel high (interleaved), the n-th beat of a burst puts out cur_addr[1:0] = start[1:0] XOR n, for n = 0 to 3, for example 01, 00, 11, 10.
- R3: When proc_strobe_n is low with en1_n low, en2 high and en3_n low, the next outputs are cur_addr = addr_in, byte_we = 0, cyc_write = 0 and deselected = 0. This holds whatever the write inputs and ctrl_strobe_n are.
- R4: proc_strobe_n has no effect while en1_n is high. en2 and en3_n have no effect on cycles where no strobe takes effect, so such a cycle acts as an advance or suspend cycle.
- R5: A strobe that takes effect while the chip is not fully selected gives deselected = 1, byte_we = 0 and cyc_write = 0. ctrl_strobe_n low, with proc_strobe_n not taking effect and the chip selected, loads addr_in and applies the decoded write strobes on that same cycle.
- R6: On a cycle with no strobe taking effect and the block not deselected, adv_n low moves to the next burst address and adv_n high keeps cur_addr unchanged.
- R7: Write decode, where bit i of byte_we and of byte_wr_n belongs to byte lane i (bit 0 = byte 1). gwrite_n low gives byte_we = all ones. Otherwise, bwr_en_n low gives byte_we[i] = !byte_wr_n[i]. Otherwise byte_we = 0. cyc_write is 1 exactly when some byte_we bit is 1.
- R8: A write on the cycle after a processor-strobe start, with adv_n high, goes to the start address.
- R9: An advance after the fourth beat returns the burst to its start address.
- R10: Reset (rst_n low at a clock edge) gives cur_addr = 0, byte_we = 0, cyc_write = 0 and deselected = 1. While deselected, cycles with no strobe taking effect keep deselected = 1 and byte_we = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| proc_strobe_n | input | 1 | Processor address strobe, active low, starts a read |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable 1, active low, also gates proc_strobe_n |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| gwrite_n | input | 1 | Global write, active low |
| bwr_en_n | input | 1 | Byte write enable, active low |
| byte_wr_n | input | NUM_BYTES | Per-byte write strobes, active low |
| order_sel | input | 1 | 0 = linear burst, 1 = interleaved burst |
| cur_addr | output | ADDR_W | Current internal word address |
| byte_we | output | NUM_BYTES | Per-byte write enables, active high |
| cyc_write | output | 1 | Current cycle is a write |
| deselected | output | 1 | Chip deselected |

## Verification
The bench builds the block with its default values: ADDR_W = 18, NUM_BYTES = 2 and BURST_LEN = 4. The 18-bit address lets start addresses with upper bits set, such as 0x2A5C1 and 0x3FFFE, show that an advance changes only the two low bits. With a four-beat burst, every start offset can wrap back to its start address in each order. The two byte lanes allow every pattern of global, per-byte and masked writes.

// File: rtl/bac_pkg.sv
// Package: shared cycle classification for the burst address controller.
// Assumes one cycle kind is decided per clock edge.
package bac_pkg;
    typedef enum logic [2:0] {
        CK_DESELECT = 3'd0,  // strobe taken while not fully selected
        CK_START_RD = 3'd1,  // processor strobe start, always a read
        CK_START_WR = 3'd2,  // controller strobe start, write as decoded
        CK_ADVANCE  = 3'd3,  // no strobe, step the burst
        CK_SUSPEND  = 3'd4,  // no strobe, keep the current word
        CK_IDLE     = 3'd5   // no strobe while deselected
    } cyc_kind_t;
endpackage

// File: rtl/bac_cycle_decode.sv
// Module: bac_cycle_decode
// Classifies the sampled strobes, enables and advance into one cycle kind.
// Assumes the processor strobe counts only when enable 1 is active, and
// that enables 2 and 3 matter only when a strobe takes effect.
module bac_cycle_decode
    import bac_pkg::*;
(
    input  logic      proc_strobe_n,
    input  logic      ctrl_strobe_n,
    input  logic      adv_n,
    input  logic      en1_n,
    input  logic      en2,
    input  logic      en3_n,
    input  logic      desel_q,
    output cyc_kind_t kind
);
    logic chip_sel;
    logic proc_take;

    assign chip_sel  = !en1_n && en2 && !en3_n;
    assign proc_take = !proc_strobe_n && !en1_n;

    // Priority: processor strobe, then controller strobe, then burst control.
    always_comb begin
        if (proc_take) begin
            kind = chip_sel ? CK_START_RD : CK_DESELECT;
        end else if (!ctrl_strobe_n) begin
            kind = chip_sel ? CK_START_WR : CK_DESELECT;
        end else if (desel_q) begin
            kind = CK_IDLE;
        end else begin
            kind = adv_n ? CK_SUSPEND : CK_ADVANCE;
        end
    end
endmodule

// File: rtl/bac_write_decode.sv
// Module: bac_write_decode
// Turns global write, byte write enable and per-byte strobes into an
// active-high lane mask. Assumes all inputs are active low.
module bac_write_decode #(
    parameter int NUM_BYTES = 2
) (
    input  logic                 gwrite_n,
    input  logic                 bwr_en_n,
    input  logic [NUM_BYTES-1:0] byte_wr_n,
    output logic [NUM_BYTES-1:0] wr_mask
);
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
        // One lane: global write wins, else a gated byte strobe.
        always_comb begin
            wr_mask[i] = !gwrite_n || (!bwr_en_n && !byte_wr_n[i]);
        end
    end
endmodule

// File: rtl/bac_burst_counter.sv
// Module: bac_burst_counter
// Holds the start offset and the beat count and forms the low address
// bits in linear or interleaved order. Assumes BURST_LEN is a power of two.
module bac_burst_counter #(
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] start_low_i,
    input  logic             interleave_i,
    output logic [CNT_W-1:0] low_o
);
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;

    // Load the start offset on a start, count beats on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (start_i) begin
            base_q <= start_low_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Order select: the sum wraps modulo the burst length, the XOR flips bits.
    always_comb begin
        low_o = interleave_i ? (base_q ^ cnt_q) : (base_q + cnt_q);
    end
endmodule

// File: rtl/burst_addr_ctrl.sv
// Module: burst_addr_ctrl (top)
// Address and write control front end of a synchronous burst SRAM.
// All outputs are registered and describe the cycle sampled at the latest
// clock edge. Assumes ADDR_W is larger than the burst counter width.
module burst_addr_ctrl
    import bac_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int NUM_BYTES = 2,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_in,
    input  logic                 proc_strobe_n,
    input  logic                 ctrl_strobe_n,
    input  logic                 adv_n,
    input  logic                 en1_n,
    input  logic                 en2,
    input  logic                 en3_n,
    input  logic                 gwrite_n,
    input  logic                 bwr_en_n,
    input  logic [NUM_BYTES-1:0] byte_wr_n,
    input  logic                 order_sel,
    output logic [ADDR_W-1:0]    cur_addr,
    output logic [NUM_BYTES-1:0] byte_we,
    output logic                 cyc_write,
    output logic                 deselected
);
    localparam int CNT_W = $clog2(BURST_LEN);
    localparam int HI_W  = ADDR_W - CNT_W;

    cyc_kind_t            kind;
    logic [NUM_BYTES-1:0] wr_mask;
    logic [CNT_W-1:0]     low_bits;
    logic [HI_W-1:0]      hi_q;
    logic [NUM_BYTES-1:0] we_q;
    logic                 wr_q;
    logic                 desel_q;
    logic                 start;
    logic                 step;

    bac_cycle_decode u_decode (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .adv_n         (adv_n),
        .en1_n         (en1_n),
        .en2           (en2),
        .en3_n         (en3_n),
        .desel_q       (desel_q),
        .kind          (kind)
    );

    bac_write_decode #(.NUM_BYTES(NUM_BYTES)) u_wdec (
        .gwrite_n  (gwrite_n),
        .bwr_en_n  (bwr_en_n),
        .byte_wr_n (byte_wr_n),
        .wr_mask   (wr_mask)
    );

    assign start = (kind == CK_START_RD) || (kind == CK_START_WR);
    assign step  = (kind == CK_ADVANCE);

    bac_burst_counter #(.BURST_LEN(BURST_LEN)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .step_i       (step),
        .start_low_i  (addr_in[CNT_W-1:0]),
        .interleave_i (order_sel),
        .low_o        (low_bits)
    );

    // Per-cycle state: upper address, select state and the write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            desel_q <= 1'b1;
            we_q    <= '0;
            wr_q    <= 1'b0;
        end else begin
            case (kind)
                CK_DESELECT: begin
                    desel_q <= 1'b1;
                    we_q    <= '0;
                    wr_q    <= 1'b0;
                end
                CK_START_RD: begin
                    hi_q    <= addr_in[ADDR_W-1:CNT_W];
                    desel_q <= 1'b0;
                    we_q    <= '0;
                    wr_q    <= 1'b0;
                end
                CK_START_WR: begin
                    hi_q    <= addr_in[ADDR_W-1:CNT_W];
                    desel_q <= 1'b0;
                    we_q    <= wr_mask;
                    wr_q    <= |wr_mask;
                end
                CK_ADVANCE, CK_SUSPEND: begin
                    we_q    <= wr_mask;
                    wr_q    <= |wr_mask;
                end
                default: begin
                    we_q    <= '0;
                    wr_q    <= 1'b0;
                end
            endcase
        end
    end

    assign cur_addr   = {hi_q, low_bits};
    assign byte_we    = we_q;
    assign cyc_write  = wr_q;
    assign deselected = desel_q;

    logic no_start;
    assign no_start = (proc_strobe_n || en1_n) && ctrl_strobe_n;

    // R3: a selected processor strobe starts a read at the external address.
    p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !en1_n && en2 && !en3_n)
        |=> (byte_we == '0 && !cyc_write && !deselected
             && cur_addr == $past(addr_in)));

    // R6: a suspend cycle keeps the word address.
    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (no_start && adv_n && !deselected)
        |=> ($stable(cur_addr) || !$stable(order_sel)));

    // R1: without a start, the upper address bits stay put.
    p_upper_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (no_start && !deselected)
        |=> (cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W])));

    // R1: a linear advance adds one to the low bits.
    p_linear_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (no_start && !adv_n && !deselected && !order_sel)
        |=> (order_sel
             || cur_addr[CNT_W-1:0] == $past(cur_addr[CNT_W-1:0]) + 1'b1));

    // R10: no strobe while deselected leaves the chip deselected and quiet.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (deselected && no_start) |=> (deselected && byte_we == '0));

    // R7: a selected controller start with global write writes every lane.
    p_global_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((proc_strobe_n || en1_n) && !ctrl_strobe_n && !en1_n && en2 && !en3_n
         && !gwrite_n)
        |=> (&byte_we && cyc_write));
endmodule

// File: tb/burst_addr_ctrl_bench.sv
// Scoreboard bench: the driver task predicts each cycle's outputs into a
// queue, and the monitor pops and compares one entry after each clock edge.
module burst_addr_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] addr_in = '0;
    logic        proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
    logic        en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
    logic        gwrite_n = 1'b1, bwr_en_n = 1'b1;
    logic [1:0]  byte_wr_n = 2'b11;
    logic        order_sel = 1'b1;
    logic [17:0] cur_addr;
    logic [1:0]  byte_we;
    logic        cyc_write, deselected;

    burst_addr_ctrl u_burst_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
        .gwrite_n(gwrite_n), .bwr_en_n(bwr_en_n), .byte_wr_n(byte_wr_n),
        .order_sel(order_sel), .cur_addr(cur_addr), .byte_we(byte_we),
        .cyc_write(cyc_write), .deselected(deselected)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [17:0] a;
        logic [1:0]  we;
        logic        wr;
        logic        ds;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    // Reference state built from the requirements.
    logic [15:0] m_hi   = '0;
    logic [1:0]  m_base = '0;
    logic [1:0]  m_cnt  = '0;
    logic        m_ds   = 1'b1;

    // Drive one cycle at the falling edge and queue its predicted outputs.
    task automatic cyc(input logic ps, input logic cs, input logic adv,
                       input logic e1, input logic e2, input logic e3,
                       input logic gw, input logic bwe, input logic [1:0] bw,
                       input logic [17:0] a, input string req);
        exp_t e;
        logic sel;
        logic [1:0] wd;
        @(negedge clk);
        proc_strobe_n = ps; ctrl_strobe_n = cs; adv_n = adv;
        en1_n = e1; en2 = e2; en3_n = e3;
        gwrite_n = gw; bwr_en_n = bwe; byte_wr_n = bw; addr_in = a;
        sel = !e1 && e2 && !e3;
        wd  = !gw ? 2'b11 : (!bwe ? ~bw : 2'b00);
        e.we = 2'b00;
        if (!ps && !e1) begin
            if (sel) begin
                m_hi = a[17:2]; m_base = a[1:0]; m_cnt = 2'd0; m_ds = 1'b0;
            end else m_ds = 1'b1;
        end else if (!cs) begin
            if (sel) begin
                m_hi = a[17:2]; m_base = a[1:0]; m_cnt = 2'd0; m_ds = 1'b0;
                e.we = wd;
            end else m_ds = 1'b1;
        end else if (!m_ds) begin
            if (!adv) m_cnt = m_cnt + 2'd1;
            e.we = wd;
        end
        e.a   = {m_hi, order_sel ? (m_base ^ m_cnt) : (m_base + m_cnt)};
        e.wr  = |e.we;
        e.ds  = m_ds;
        e.req = req;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge; the address counts only when selected.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (e.we !== byte_we || e.wr !== cyc_write || e.ds !== deselected
                || (!e.ds && e.a !== cur_addr)) begin
                n_fail++;
                $display("FAIL %s: addr=%h we=%b wr=%b ds=%b expected addr=%h we=%b wr=%b ds=%b",
                         e.req, cur_addr, byte_we, cyc_write, deselected,
                         e.a, e.we, e.wr, e.ds);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        // R10: reset state
        if (cur_addr !== 18'h0 || byte_we !== 2'b00 || cyc_write !== 1'b0
            || deselected !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 reset: addr=%h we=%b wr=%b ds=%b expected addr=00000 we=00 wr=0 ds=1",
                     cur_addr, byte_we, cyc_write, deselected);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 linear order and R9 wrap
        order_sel = 1'b0;
        cyc(1,0,1, 0,1,0, 1,1,2'b11, 18'h2A5C1, "R1");
        cyc(1,1,0, 1,0,1, 1,1,2'b11, 18'h3FFFF, "R1");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R1");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R1");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R9");

        // R3 read despite write inputs, R2 interleaved order, R9 wrap
        order_sel = 1'b1;
        cyc(0,1,1, 0,1,0, 0,0,2'b00, 18'h15A35, "R3");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R2");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R2");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R2");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R9");
        // R6 suspend repeats the word
        cyc(1,1,1, 0,1,0, 1,1,2'b11, 18'h00000, "R6");
        cyc(1,1,1, 0,1,0, 1,1,2'b11, 18'h00000, "R6");

        // R8 write after a processor start, R7 global write on a step
        cyc(0,1,1, 0,1,0, 1,1,2'b11, 18'h00102, "R3");
        cyc(1,1,1, 0,1,0, 1,0,2'b10, 18'h00000, "R8");
        cyc(1,1,0, 0,1,0, 0,1,2'b11, 18'h00000, "R7");
        // R4 processor strobe masked by enable 1, enables 2/3 ignored
        cyc(0,1,0, 1,0,1, 1,1,2'b11, 18'h3FFFF, "R4");
        cyc(1,1,0, 0,0,1, 1,1,2'b11, 18'h3FFFF, "R4");

        // R5 deselect via enables, R10 stays deselected
        cyc(1,0,1, 0,0,0, 1,1,2'b11, 18'h11111, "R5");
        cyc(1,1,0, 0,1,0, 0,0,2'b00, 18'h00000, "R10");
        cyc(1,1,1, 0,1,0, 0,1,2'b11, 18'h00000, "R10");
        cyc(0,1,1, 0,1,1, 1,1,2'b11, 18'h22222, "R5");
        cyc(1,0,1, 1,1,0, 1,1,2'b11, 18'h22222, "R5");

        // R5 controller start with write, R7 write decode patterns
        cyc(1,0,1, 0,1,0, 0,1,2'b11, 18'h3FFFE, "R7");
        cyc(1,0,1, 0,1,0, 1,0,2'b01, 18'h01234, "R7");
        cyc(1,0,1, 0,1,0, 1,0,2'b10, 18'h01235, "R5");
        cyc(1,0,1, 0,1,0, 1,0,2'b11, 18'h01236, "R7");
        cyc(1,0,1, 0,1,0, 1,1,2'b00, 18'h01237, "R7");
        // R3 processor strobe wins over controller strobe
        cyc(0,0,1, 0,1,0, 0,0,2'b00, 18'h0ABCD, "R3");

        // R1 linear wrap from offset 3 keeps upper bits
        order_sel = 1'b0;
        cyc(1,0,1, 0,1,0, 1,1,2'b11, 18'h0000F, "R1");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R1");
        cyc(1,1,0, 0,1,0, 1,1,2'b11, 18'h00000, "R1");
        cyc(1,1,1, 0,1,0, 1,1,2'b11, 18'h00000, "R6");

        @(posedge clk);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule